// File: doc/BRIEF.md
# Event Counter Bank with Overflow Status

This block holds a set of programmable event counters and a smaller set of fixed-function counters. Each cycle, each counter can add a small occurrence count, 0 to 7, taken from an event lane. A counter runs only when its own control allows it and its bit in a shared run-control register is set. Its own control is a select register for a general counter, or a 4-bit field of a packed control register for a fixed counter. Each control also qualifies counting by the current privilege mode.

Counters wrap inside an implemented width. A wrap past all-ones sets the counter's bit in a shared overflow status register. Software clears status bits through a write-one-to-clear address. An interrupt level is raised while any set status bit belongs to a counter that has its interrupt-enable bit set. All state is reached through one write port and one read port with a registered read.

Top module: `evbank_top`

Register map (5-bit address, 64-bit data):
- 0x00+i: general counter i
- 0x08+i: general select i
- 0x10+j: fixed counter j
- 0x18: fixed control
- 0x19: run-control
- 0x1A: status (read-only)
- 0x1B: status clear (write-only, reads 0)

Select register fields:
- bits 7:0: event lane code
- bit 16: count in supervisor mode
- bit 17: count in user mode
- bit 20: interrupt on overflow
- bit 22: local enable
- bits 26:24: threshold

Run-control and status use the same bit positions: bit i is general counter i, and bit 32+j is fixed counter j.

## Requirements
- R1: After reset, every counter, select, control and status register reads zero and `ovf_irq` is low.
- R2: A counter write keeps only the low CNT_W bits; the bits above CNT_W read back as zero.
- R3: A general counter adds the occurrence count of the lane named by its event code each cycle. This happens only when bit 22 is set, its run-control bit is set, and the mode qualifier for the current mode is set: bit 16 when `priv_user`=0, bit 17 when `priv_user`=1. Code values of NUM_EV or above select no lane.
- R4: Clearing either the local enable or the run-control bit freezes the count.
- R5: A non-zero threshold (bits 26:24) makes the counter add exactly 1 in cycles where the occurrence count is at least the threshold, and 0 otherwise.
- R6: Fixed counter j counts fixed lane j and is controlled by field bits [4j+3:4j] of the fixed control register: bit 0 supervisor, bit 1 user, bit 3 interrupt on overflow.
- R7: A counter that wraps past all-ones keeps the wrapped value and sets status bit i (general) or 32+j (fixed) at the same clock edge.
- R8: Writing a mask to 0x1B clears those status bits; a status bit set by overflow in the same cycle stays set.
- R9: `ovf_irq` changes at the same edge as status and is high exactly while a set status bit belongs to a counter whose interrupt bit is set; overflow without that bit leaves `ovf_irq` low.
- R10: A write to a running counter replaces the count in that cycle, discarding that cycle's events; an all-ones preset overflows on the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| ev_occ | input | NUM_EV*3 | Per-cycle occurrence counts of the general event lanes |
| fx_occ | input | NUM_FX*3 | Per-cycle occurrence counts of the fixed lanes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 64 | Read data, registered one cycle after `rd_addr` |
| ovf_irq | output | 1 | Overflow interrupt level |

## Verification
On every cycle, the assertions check several relations. A stopped counter holds its value, a counter write takes effect, and a thresholded counter never moves by more than one. An overflow lands in status, a cleared bit drops unless it is set again, and an empty status register keeps the interrupt low. Lane selection, the privilege qualifiers, the threshold arithmetic and the fixed-field bit positions are shown only by the bench's table and directed scenarios. So are the exact wrapped value and whether the interrupt follows the interrupt-enable bits.

// File: rtl/evbank_pkg.sv
package evbank_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 5;
  localparam int OCC_W  = 3;
  localparam int FX_BASE = 32;

  localparam logic [ADDR_W-1:0] A_GPCNT = 5'h00;
  localparam logic [ADDR_W-1:0] A_GPSEL = 5'h08;
  localparam logic [ADDR_W-1:0] A_FXCNT = 5'h10;
  localparam logic [ADDR_W-1:0] A_FXCTL = 5'h18;
  localparam logic [ADDR_W-1:0] A_RUN   = 5'h19;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h1A;
  localparam logic [ADDR_W-1:0] A_CLR   = 5'h1B;

  localparam int B_OS  = 16;
  localparam int B_USR = 17;
  localparam int B_INT = 20;
  localparam int B_EN  = 22;
  localparam int B_THR = 24;

  localparam logic [DATA_W-1:0] SEL_MASK =
    64'hFF | (64'h1 << B_OS) | (64'h1 << B_USR) | (64'h1 << B_INT) |
    (64'h1 << B_EN) | (64'h7 << B_THR);

  typedef struct packed {
    logic [7:0]       code;
    logic             os;
    logic             usr;
    logic             intr;
    logic             en;
    logic [OCC_W-1:0] thr;
  } sel_t;

  function automatic sel_t to_sel(input logic [DATA_W-1:0] d);
    sel_t s;
    s.code = d[7:0];
    s.os   = d[B_OS];
    s.usr  = d[B_USR];
    s.intr = d[B_INT];
    s.en   = d[B_EN];
    s.thr  = d[B_THR +: OCC_W];
    return s;
  endfunction
endpackage

// File: rtl/evbank_counter.sv
module evbank_counter #(
  parameter int CNT_W = 48,
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [OCC_W-1:0] inc;
  logic [CNT_W:0]   sum;

  always_comb begin
    if (!run)                inc = '0;
    else if (thr == '0)      inc = occ;
    else if (occ >= thr)     inc = OCC_W'(1);
    else                     inc = '0;
  end

  assign sum = {1'b0, cnt} + (CNT_W+1)'(inc);
  assign ovf = !load && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= sum[CNT_W-1:0];
  end

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
  // R10
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
  // R5
  thr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && thr != '0) |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));
endmodule

// File: rtl/evbank_status.sv
module evbank_status #(
  parameter int STAT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_v,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] ie_v,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] status_d;

  assign status_d = (status & ~(clr_we ? clr_mask : '0)) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |(status_d & ie_v);
    end
  end

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));
  // R8
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && |(clr_mask & ~set_v)) |=> ((status & $past(clr_mask & ~set_v)) == '0));
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> !irq);
endmodule

// File: rtl/evbank_top.sv
module evbank_top
  import evbank_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int NUM_EV = 8,
  parameter int CNT_W  = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    priv_user,
  input  logic [NUM_EV*OCC_W-1:0] ev_occ,
  input  logic [NUM_FX*OCC_W-1:0] fx_occ,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    ovf_irq
);
  localparam logic [DATA_W-1:0] RUN_MASK =
    ((64'h1 << NUM_GP) - 64'h1) | (((64'h1 << NUM_FX) - 64'h1) << FX_BASE);
  localparam int FXC_W = 4 * NUM_FX;

  logic [DATA_W-1:0] sel_raw [NUM_GP];
  logic [FXC_W-1:0]  fxctl_q;
  logic [DATA_W-1:0] run_q;
  logic [CNT_W-1:0]  gp_cnt [NUM_GP];
  logic [CNT_W-1:0]  fx_cnt [NUM_FX];
  logic [NUM_GP-1:0] gp_ovf, gp_ie;
  logic [NUM_FX-1:0] fx_ovf, fx_ie;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      fxctl_q <= '0;
      run_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_FXCTL) fxctl_q <= wr_data[FXC_W-1:0];
      if (wr_addr == A_RUN)   run_q   <= wr_data & RUN_MASK;
    end
  end

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    sel_t             s;
    logic [OCC_W-1:0] lane;
    logic             run;

    always_ff @(posedge clk) begin
      if (rst) sel_raw[i] <= '0;
      else if (wr_en && wr_addr == A_GPSEL + ADDR_W'(i)) sel_raw[i] <= wr_data & SEL_MASK;
    end

    assign s = to_sel(sel_raw[i]);

    always_comb begin
      lane = '0;
      for (int k = 0; k < NUM_EV; k++)
        if (s.code == 8'(k)) lane = ev_occ[k*OCC_W +: OCC_W];
    end

    assign run      = s.en && run_q[i] && (priv_user ? s.usr : s.os);
    assign gp_ie[i] = s.intr;

    evbank_counter #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_cnt (
      .clk(clk), .rst(rst),
      .load(wr_en && wr_addr == A_GPCNT + ADDR_W'(i)),
      .load_val(wr_data[CNT_W-1:0]),
      .run(run), .occ(lane), .thr(s.thr),
      .cnt(gp_cnt[i]), .ovf(gp_ovf[i])
    );
  end

  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    logic [3:0] fld;
    logic       run;

    assign fld      = fxctl_q[4*j +: 4];
    assign run      = run_q[FX_BASE+j] && (priv_user ? fld[1] : fld[0]);
    assign fx_ie[j] = fld[3];

    evbank_counter #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_cnt (
      .clk(clk), .rst(rst),
      .load(wr_en && wr_addr == A_FXCNT + ADDR_W'(j)),
      .load_val(wr_data[CNT_W-1:0]),
      .run(run), .occ(fx_occ[j*OCC_W +: OCC_W]), .thr('0),
      .cnt(fx_cnt[j]), .ovf(fx_ovf[j])
    );
  end

  evbank_status #(.STAT_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst),
    .set_v(DATA_W'(gp_ovf) | (DATA_W'(fx_ovf) << FX_BASE)),
    .clr_we(wr_en && wr_addr == A_CLR),
    .clr_mask(wr_data),
    .ie_v(DATA_W'(gp_ie) | (DATA_W'(fx_ie) << FX_BASE)),
    .status(status),
    .irq(ovf_irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_GP; k++) begin
      if (rd_addr == A_GPCNT + ADDR_W'(k)) rd_mux = DATA_W'(gp_cnt[k]);
      if (rd_addr == A_GPSEL + ADDR_W'(k)) rd_mux = sel_raw[k];
    end
    for (int k = 0; k < NUM_FX; k++)
      if (rd_addr == A_FXCNT + ADDR_W'(k)) rd_mux = DATA_W'(fx_cnt[k]);
    if (rd_addr == A_FXCTL) rd_mux = DATA_W'(fxctl_q);
    if (rd_addr == A_RUN)   rd_mux = run_q;
    if (rd_addr == A_STAT)  rd_mux = status;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: tb/evbank_top_test.sv
module evbank_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_user = 1'b0;
  logic [23:0] ev_occ = '0;
  logic [8:0]  fx_occ = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        ovf_irq;
  int          total = 0;
  int          fails = 0;

  localparam logic [63:0] ONES48 = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [63:0] RUN_ALL = 64'h0000_0007_0000_000F;

  // [15:13] occ, [12:10] thr, [9] priv_user, [8] os, [7] usr, [2:0] expected delta
  localparam logic [15:0] VEC [10] = '{
    {3'd5, 3'd0, 1'b0, 1'b1, 1'b0, 4'd0, 3'd5},
    {3'd5, 3'd0, 1'b1, 1'b1, 1'b0, 4'd0, 3'd0},
    {3'd5, 3'd0, 1'b1, 1'b0, 1'b1, 4'd0, 3'd5},
    {3'd3, 3'd4, 1'b0, 1'b1, 1'b0, 4'd0, 3'd0},
    {3'd4, 3'd4, 1'b0, 1'b1, 1'b0, 4'd0, 3'd1},
    {3'd7, 3'd2, 1'b0, 1'b1, 1'b0, 4'd0, 3'd1},
    {3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd0, 3'd0},
    {3'd7, 3'd0, 1'b0, 1'b1, 1'b1, 4'd0, 3'd7},
    {3'd1, 3'd1, 1'b0, 1'b1, 1'b0, 4'd0, 3'd1},
    {3'd2, 3'd7, 1'b0, 1'b1, 1'b0, 4'd0, 3'd0}
  };

  evbank_top uut (
    .clk(clk), .rst(rst), .priv_user(priv_user), .ev_occ(ev_occ), .fx_occ(fx_occ),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ovf_irq(ovf_irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse(input logic [23:0] ev, input logic [8:0] fx, input int n);
    ev_occ = ev; fx_occ = fx;
    repeat (n) @(negedge clk);
    ev_occ = '0; fx_occ = '0;
  endtask

  initial begin
    #(8 * 100000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, v); chk("R1 counter0", v, 64'h0);
    rd(5'h12, v); chk("R1 fixed2", v, 64'h0);
    rd(5'h19, v); chk("R1 run-control", v, 64'h0);
    rd(5'h1A, v); chk("R1 status", v, 64'h0);
    chk("R1 irq", {63'h0, ovf_irq}, 64'h0);

    // R2 width masking
    wr(5'h01, 64'hFFFF_FF01_2345_6789);
    rd(5'h01, v); chk("R2 masked readback", v, 64'h0000_FF01_2345_6789);

    wr(5'h19, RUN_ALL);

    // R3 R5 table walk on counter 0, lane 3
    foreach (VEC[n]) begin
      logic [63:0] sel;
      logic [23:0] ev;
      sel = 64'h3 | (64'h1 << 22) | (64'(VEC[n][8]) << 16) | (64'(VEC[n][7]) << 17) |
            (64'(VEC[n][12:10]) << 24);
      wr(5'h00, 64'h0);
      wr(5'h08, sel);
      ev = 24'hFFFFFF;
      ev[9 +: 3] = VEC[n][15:13];
      priv_user = VEC[n][9];
      pulse(ev, 9'h0, 1);
      priv_user = 1'b0;
      rd(5'h00, v);
      chk($sformatf("R3/R5 vector %0d", n), v, 64'(VEC[n][2:0]));
    end

    // R4 freeze by run-control and by local enable
    wr(5'h08, 64'h0041_0003);
    wr(5'h00, 64'd10);
    wr(5'h19, RUN_ALL & ~64'h1);
    pulse(24'h4 << 9, 9'h0, 2);
    rd(5'h00, v); chk("R4 run-control cleared", v, 64'd10);
    wr(5'h19, RUN_ALL);
    wr(5'h08, 64'h0001_0003);
    pulse(24'h4 << 9, 9'h0, 2);
    rd(5'h00, v); chk("R4 local enable cleared", v, 64'd10);
    wr(5'h08, 64'h0041_0003);
    pulse(24'h4 << 9, 9'h0, 1);
    rd(5'h00, v); chk("R4 resumed", v, 64'd14);

    // R10 write while running
    ev_occ = 24'h2 << 9;
    wr(5'h00, 64'd100);
    ev_occ = '0;
    rd(5'h00, v); chk("R10 write replaces count", v, 64'd100);
    pulse(24'h2 << 9, 9'h0, 1);
    rd(5'h00, v); chk("R10 counts after write", v, 64'd102);

    // R7 R9 overflow with interrupt on counter 1
    wr(5'h09, 64'h0051_0001);
    wr(5'h01, ONES48);
    pulse(24'h1 << 3, 9'h0, 1);
    chk("R9 irq on enabled overflow", {63'h0, ovf_irq}, 64'h1);
    rd(5'h01, v); chk("R7 wrapped to zero", v, 64'h0);
    rd(5'h1A, v); chk("R7 status bit1", v, 64'h2);
    // R8 clear
    wr(5'h1B, 64'h2);
    chk("R9 irq drops after clear", {63'h0, ovf_irq}, 64'h0);
    rd(5'h1A, v); chk("R8 status cleared", v, 64'h0);

    // R9 overflow without interrupt on counter 2
    wr(5'h0A, 64'h0041_0002);
    wr(5'h02, ONES48 - 64'h1);
    pulse(24'h3 << 6, 9'h0, 1);
    chk("R9 no irq without enable", {63'h0, ovf_irq}, 64'h0);
    rd(5'h02, v); chk("R7 wrap keeps remainder", v, 64'h1);
    rd(5'h1A, v); chk("R7 status bit2", v, 64'h4);
    wr(5'h1B, 64'h4);

    // R10 all-ones preset overflows on the next event
    wr(5'h00, ONES48);
    pulse(24'h1 << 9, 9'h0, 1);
    rd(5'h1A, v); chk("R10 preset overflow status", v, 64'h1);
    wr(5'h1B, 64'h1);

    // R6 fixed counter 1
    wr(5'h18, 64'h90);
    pulse(24'h0, 9'h2 << 3, 3);
    rd(5'h11, v); chk("R6 fixed supervisor count", v, 64'd6);
    priv_user = 1'b1;
    pulse(24'h0, 9'h2 << 3, 2);
    rd(5'h11, v); chk("R6 fixed user blocked", v, 64'd6);
    wr(5'h18, 64'h20);
    pulse(24'h0, 9'h3 << 3, 1);
    priv_user = 1'b0;
    rd(5'h11, v); chk("R6 fixed user count", v, 64'd9);
    wr(5'h18, 64'h90);
    wr(5'h11, ONES48);
    pulse(24'h0, 9'h1 << 3, 1);
    chk("R9 fixed irq", {63'h0, ovf_irq}, 64'h1);
    rd(5'h1A, v); chk("R7 fixed status bit33", v, 64'h2_0000_0000);
    wr(5'h1B, 64'h2_0000_0000);
    chk("R8 fixed clear drops irq", {63'h0, ovf_irq}, 64'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule